// File: doc/BRIEF.md
# Quad Pulse Timer

The block holds four independent one-shot channels that run on one clock. When a channel is triggered, its output goes high on the next clock edge. It stays high for exactly 100 clock cycles and then goes low. Each channel counts with a linear-feedback shift register. The register is loaded with a fixed nonzero seed when the channel starts, and the channel stops when the register reaches the state that lies 99 steps past the seed. A binary up-counter is not used.

There are three ways to start a channel:

- **Common start:** a common start line launches all four channels at once. The trigger-block line does not affect it.
- **Strobed start:** each channel has its own set line. That channel starts when its set line is high in a cycle where a strobe edge is seen on either strobe line.
  - One strobe line responds to a rising edge.
  - The other strobe line responds to a falling edge.
  - Each strobe edge is found by comparing the strobe input with its value registered at the previous clock.
- **Blocking:** a trigger-block line suppresses strobed starts.

A separate kill line forces all pulse outputs low while it is high. It does not stop or reset the counting. A busy flag for each channel shows the true state of that channel's timer.

Top module: `quad_pulse_timer`

## Requirements
- R1: While `rst_ni` is low, every bit of `pulse_o` and `busy_o` is 0. This holds at once, even in the middle of a pulse, and stays so until triggered again after reset is released.
- R2: Driving `all_set_i` high for one clock sets all four bits of `busy_o` and `pulse_o` at the following edge. `trig_block_i` has no effect on this.
- R3: Channel i (bit i of the 4-bit vectors) starts at the next edge when `chan_set_i[i]` is 1 in a cycle where `strobe_rise_i` is 1 and was 0 at the previous clock.
- R4: Channel i starts at the next edge when `chan_set_i[i]` is 1 in a cycle where `strobe_fall_i` is 0 and was 1 at the previous clock.
- R5: A set line that is high with no strobe edge starts nothing. This includes a strobe that is held at a steady level.
- R6: While `trig_block_i` is 1, strobe edges start no channel.
- R7: After a start, `busy_o[i]` is high for exactly 100 consecutive clock cycles. The count is made by an LFSR with a seed and a terminal state fixed at elaboration.
- R8: A start condition seen while a channel is busy is ignored. The channel's end cycle does not change.
- R9: While `out_kill_i` is 1, `pulse_o` is all zeros and `busy_o` keeps counting. If the kill is released inside the window, the pulse reappears and still ends on schedule. With kill low, `pulse_o` equals `busy_o`.
- R10: The channels time independently of one another. Channels started at different cycles end 100 cycles after their own starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all channels |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_set_i | input | 4 | Per-channel set lines, bit i selects channel i |
| all_set_i | input | 1 | Common start for all channels |
| strobe_rise_i | input | 1 | Strobe that acts on its rising edge |
| strobe_fall_i | input | 1 | Strobe that acts on its falling edge |
| trig_block_i | input | 1 | Suppresses strobed starts while high |
| out_kill_i | input | 1 | Forces all pulse outputs low while high |
| pulse_o | output | 4 | Active-high timed pulse outputs |
| busy_o | output | 4 | Per-channel timer-running flags |

## Verification
The bench checks whether the strobes react only to transitions. A design that triggered on level would start channels when a strobe is held high or held low. A design that inverted the falling-edge strobe would miss the high-to-low case.

The bench measures the pulse width cycle by cycle against a plain counter, so an off-by-one terminal state shows up as 99 or 101 cycles. A second start issued in the middle of a pulse shows whether a design reseeds the running channel: if it does, that channel ends late, while the newly started channels must still end 100 cycles after their own start.

Kill is raised in the middle of a pulse. A design that stops or clears the counter under kill would lose the pulse after kill is released, or would lengthen the busy window.

// File: rtl/qpt_pkg.sv
package qpt_pkg;

  // Which transition of a strobe line counts as an event.
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  // Default geometry of the timer.
  localparam int unsigned QPT_CHANNELS  = 4;
  localparam int unsigned QPT_PULSE_LEN = 100;
  localparam int unsigned QPT_LFSR_W    = 7;

endpackage

// File: rtl/qpt_reset_sync.sv
module qpt_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // Assert at once, release only after STAGES clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/qpt_edge.sv
module qpt_edge
  import qpt_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic event_o
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign event_o = level_i & ~prev_q;
    end else begin : g_fall
      assign event_o = ~level_i & prev_q;
    end
  endgenerate

endmodule

// File: rtl/qpt_channel.sv
module qpt_channel #(
  parameter int unsigned       PULSE_LEN = 100,
  parameter int unsigned       LFSR_W    = 7,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 7'h60,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 7'h01
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);

  // Fibonacci shift: feedback is the parity of the tapped bits.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_walk(input logic [LFSR_W-1:0] s,
                                                  input int unsigned n);
    logic [LFSR_W-1:0] r;
    r = s;
    for (int unsigned k = 0; k < n; k++) begin
      r = lfsr_step(r);
    end
    return r;
  endfunction

  // State held in the last cycle of the window.
  localparam logic [LFSR_W-1:0] TERM_STATE = lfsr_walk(LFSR_SEED, PULSE_LEN - 1);
  localparam int unsigned       CHK_W      = $clog2(PULSE_LEN + 1);

  logic              active_q, active_d;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic              start, done, lfsr_en;

  always_comb begin
    start   = fire_i & ~active_q;
    done    = active_q & (lfsr_q == TERM_STATE);
    lfsr_en = start | active_q;
    active_d = start | (active_q & ~done);
    if (start) begin
      lfsr_d = LFSR_SEED;
    end else begin
      lfsr_d = lfsr_step(lfsr_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
    end else begin
      active_q <= active_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= LFSR_SEED;
    end else if (lfsr_en) begin
      lfsr_q <= lfsr_d;
    end
  end

  assign active_o = active_q;

  // Plain cycle counter, used only by the checks below.
  logic [CHK_W-1:0] chk_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_cnt_q <= '0;
    end else if (start) begin
      chk_cnt_q <= '0;
    end else if (active_q) begin
      chk_cnt_q <= chk_cnt_q + 1'b1;
    end
  end

  // R7
  width_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (chk_cnt_q < CHK_W'(PULSE_LEN)));

  // R7
  width_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> ($past(chk_cnt_q) == CHK_W'(PULSE_LEN - 1)));

  // R8
  no_reseed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && fire_i && (chk_cnt_q < CHK_W'(PULSE_LEN - 1))) |=>
      (active_q && (chk_cnt_q == $past(chk_cnt_q) + 1'b1)));

  // R7
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> (lfsr_q == LFSR_SEED));

endmodule

// File: rtl/quad_pulse_timer.sv
module quad_pulse_timer
  import qpt_pkg::*;
#(
  parameter int unsigned NUM_CH    = QPT_CHANNELS,
  parameter int unsigned PULSE_LEN = QPT_PULSE_LEN,
  parameter int unsigned LFSR_W    = QPT_LFSR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] chan_set_i,
  input  logic              all_set_i,
  input  logic              strobe_rise_i,
  input  logic              strobe_fall_i,
  input  logic              trig_block_i,
  input  logic              out_kill_i,
  output logic [NUM_CH-1:0] pulse_o,
  output logic [NUM_CH-1:0] busy_o
);

  localparam logic [LFSR_W-1:0] TAPS = LFSR_W'(7'h60);
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);

  logic              rst_sync_n;
  logic              rise_evt, fall_evt, strobe_hit;
  logic [NUM_CH-1:0] fire;

  qpt_reset_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  qpt_edge #(.KIND(EDGE_RISE)) u_edge_rise (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .level_i (strobe_rise_i),
    .event_o (rise_evt)
  );

  qpt_edge #(.KIND(EDGE_FALL)) u_edge_fall (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .level_i (strobe_fall_i),
    .event_o (fall_evt)
  );

  always_comb begin
    strobe_hit = (rise_evt | fall_evt) & ~trig_block_i;
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      always_comb begin
        fire[g] = all_set_i | (chan_set_i[g] & strobe_hit);
      end

      qpt_channel #(
        .PULSE_LEN (PULSE_LEN),
        .LFSR_W    (LFSR_W),
        .LFSR_TAPS (TAPS),
        .LFSR_SEED (SEED)
      ) u_chan (
        .clk_i    (clk_i),
        .rst_ni   (rst_sync_n),
        .fire_i   (fire[g]),
        .active_o (busy_o[g])
      );
    end
  endgenerate

  always_comb begin
    pulse_o = busy_o & {NUM_CH{~out_kill_i}};
  end

  // R2
  common_start_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    all_set_i |=> (&busy_o));

  // R6
  block_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (trig_block_i && !all_set_i) |=> ((busy_o & ~$past(busy_o)) == '0));

  // R5
  no_event_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!all_set_i && !strobe_hit) |=> ((busy_o & ~$past(busy_o)) == '0));

endmodule

// File: tb/quad_pulse_timer_tb.sv
module quad_pulse_timer_tb_top;

  logic       clk;
  logic       rst_n;
  logic [3:0] chan_set;
  logic       all_set;
  logic       s_rise;
  logic       s_fall;
  logic       blk;
  logic       kill;
  logic [3:0] pulse;
  logic [3:0] busy;

  int n_checks = 0;
  int n_fails  = 0;

  quad_pulse_timer dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .chan_set_i    (chan_set),
    .all_set_i     (all_set),
    .strobe_rise_i (s_rise),
    .strobe_fall_i (s_fall),
    .trig_block_i  (blk),
    .out_kill_i    (kill),
    .pulse_o       (pulse),
    .busy_o        (busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector fields: [13] rise before, [12] fall before, [11:8] set lines,
  // [7] common start, [6] rise now, [5] fall now, [4] block, [3:0] expected busy.
  localparam int NVEC = 10;
  localparam logic [13:0] VEC [NVEC] = '{
    14'b0_0_0101_0_1_0_0_0101,  // R3 rising edge starts selected channels
    14'b1_0_1111_0_1_0_0_0000,  // R5 held-high rise strobe
    14'b0_1_0011_0_0_0_0_0011,  // R4 falling edge starts selected channels
    14'b0_0_0011_0_0_0_0_0000,  // R5 held-low fall strobe
    14'b0_0_1111_0_1_0_1_0000,  // R6 rising edge blocked
    14'b0_0_0000_1_0_0_1_1111,  // R2 common start ignores block
    14'b0_1_1000_0_0_0_1_0000,  // R6 falling edge blocked
    14'b0_0_1111_0_0_0_0_0000,  // R5 set lines without strobe
    14'b0_1_0110_0_1_0_0_0110,  // R3 R4 both edges together
    14'b0_1_1001_1_1_0_0_1111   // R2 common start with strobes
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    chan_set = 4'b0;
    all_set  = 1'b0;
    s_rise   = 1'b0;
    s_fall   = 1'b0;
    blk      = 1'b0;
    kill     = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #500us;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 4'b0000);
    check("R1 reset pulse", pulse, 4'b0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after release", busy, 4'b0000);

    // Table walk: one start cycle per vector, each from a fresh reset.
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      s_rise = VEC[v][13];
      s_fall = VEC[v][12];
      @(negedge clk);
      chan_set = VEC[v][11:8];
      all_set  = VEC[v][7];
      s_rise   = VEC[v][6];
      s_fall   = VEC[v][5];
      blk      = VEC[v][4];
      @(negedge clk);
      check($sformatf("R2-6 vector %0d busy", v), busy, VEC[v][3:0]);
      check($sformatf("R9 vector %0d pulse", v), pulse, VEC[v][3:0]);
    end

    // R7 width against a reference counter.
    begin
      int width;
      do_reset();
      chan_set = 4'b0001;
      s_rise   = 1'b1;
      @(negedge clk);
      idle_inputs();
      width = 0;
      while (busy[0] && width < 300) begin
        width++;
        @(negedge clk);
      end
      check_int("R7 pulse width", width, 100);
      check("R7 all idle after end", busy, 4'b0000);
    end

    // R8 retrigger ignored, R10 independent channels.
    begin
      int fall_at [4];
      logic [3:0] prev;
      do_reset();
      for (int k = 0; k < 4; k++) fall_at[k] = -1;
      prev = 4'b0;
      for (int c = 0; c < 200; c++) begin
        idle_inputs();
        if (c == 0) begin
          chan_set = 4'b0010;
          s_rise   = 1'b1;
        end
        if (c == 30) all_set = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          if (prev[k] && !busy[k] && fall_at[k] < 0) fall_at[k] = c;
        end
        prev = busy;
      end
      check_int("R8 retriggered channel end", fall_at[1], 100);
      check_int("R10 later channel 0 end", fall_at[0], 130);
      check_int("R10 later channel 3 end", fall_at[3], 130);
    end

    // R9 kill masks output without disturbing the count.
    begin
      int hi;
      int miss;
      do_reset();
      hi = 0;
      miss = 0;
      for (int c = 0; c < 150; c++) begin
        idle_inputs();
        if (c == 0) begin
          chan_set = 4'b1000;
          s_rise   = 1'b1;
        end
        kill = (c >= 10 && c < 30);
        @(negedge clk);
        if (busy[3]) hi++;
        if (c < 100) begin
          if (busy[3] !== 1'b1) miss++;
          if (pulse[3] !== !(c >= 10 && c < 30)) miss++;
        end
        if (kill && pulse !== 4'b0000) miss++;
      end
      check_int("R9 kill window mismatches", miss, 0);
      check_int("R9 busy cycles under kill", hi, 100);
    end

    // R1 reset in the middle of a pulse.
    begin
      do_reset();
      all_set = 1'b1;
      @(negedge clk);
      idle_inputs();
      repeat (5) @(negedge clk);
      check("R1 busy before reset", busy, 4'b1111);
      rst_n = 1'b0;
      #1;
      check("R1 async clear busy", busy, 4'b0000);
      check("R1 async clear pulse", pulse, 4'b0000);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 stays idle", busy, 4'b0000);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule